// File: doc/BRIEF.md
# Push-Pull Pulse-Skip Gate

This block sits between a PWM pulse generator and the gate drivers of a push-pull power stage. It runs on a fast sampling clock. Once per switching period, a single-cycle `sys_tick` strobe marks the rising edge of the system switching clock. On that strobe the block decides whether to let the coming primary pulse through or to suppress it for the whole period. The decision needs two things together: a comparator flag saying the control voltage is below its low threshold, and a previous period whose issued duty was under one quarter.

The block measures that duty itself. It counts the fast-clock cycles in which a primary output was high and the cycles in the period, so a suppressed period counts as zero duty. In push-pull mode the primary pulses alternate between phase A and phase B. A balance tracker only allows a skip on the phase that is not already ahead in skips, which keeps the volt-seconds on the transformer equal. The two synchronous-rectifier outputs are held on through a skipped period once soft-start is complete, and stay off before that. In single-ended mode only phase A is used and no balancing applies.

Top module: `pskip_gate`

## Requirements
- R1: While `rst_n` is low, at the next clock edge all four outputs are low and the skip balance is zero.
- R2: At a `sys_tick` edge the coming period is skipped only when `cmp_low` is high at that edge and the previous period's issued on-count N and length P satisfy 4·N < P. A duty of exactly 25% or more, or a low `cmp_low`, gives a normal pulse.
- R3: In a skipped period the active primary output stays low for the whole period, and that period is measured as zero duty.
- R4: In a normal period the active primary output copies `pwm_in` with one clock of delay. In push-pull mode (`pp_mode`=1) the first period after reset is phase A and phases then alternate A, B, A, and so on. `pri_a` and `pri_b` are never high together.
- R5: With `ss_done` high, both rectifier outputs are high throughout a skipped push-pull period. In a normal period `sr_a` is the inverse of `pri_b` and `sr_b` is the inverse of `pri_a`, both registered one clock after the inputs.
- R6: With `ss_done` low, both rectifier outputs are low, including in skipped periods.
- R7: In push-pull mode the skip counts of A and B never differ by more than one. A skip is refused on the phase that is ahead, and with skip conditions held the counts are equal after every A/B pair.
- R8: In single-ended mode (`pp_mode`=0) every period is phase A. Skips need no balancing, `pri_b` and `sr_b` stay low, and `sr_a` is the inverse of `pri_a` gated by `ss_done`.
- R9: The first period after reset is never skipped, whatever `cmp_low` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_tick | input | 1 | One-cycle strobe at each switching-clock rising edge |
| pwm_in | input | 1 | Raw PWM pulse of the current period |
| cmp_low | input | 1 | Control voltage below low threshold |
| ss_done | input | 1 | Soft-start complete |
| pp_mode | input | 1 | 1 = push-pull 50% limit, 0 = single-ended |
| pri_a | output | 1 | Primary switch output, phase A |
| pri_b | output | 1 | Primary switch output, phase B |
| sr_a | output | 1 | Synchronous-rectifier output A |
| sr_b | output | 1 | Synchronous-rectifier output B |

## Verification
The bench drives duty exactly at the 25% boundary, where an off-by-one compare (`<=` instead of `<`) would skip a pulse that must be issued. It lets one phase take a lone skip and then asserts the skip conditions on that same phase. A tracker that ignored which phase leads would skip twice in a row there and unbalance the transformer. It enables skipping both before and after soft-start, so rectifier gating that used the wrong soft-start sense would show as rectifiers on too early or off during skips. It also raises `cmp_low` on the first period after reset, where the empty duty counters would otherwise look like zero duty.

// File: rtl/pskip_pkg.sv
package pskip_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   run;
        logic   skip;
        logic   pri_a;
        logic   pri_b;
        logic   sr_a;
        logic   sr_b;
    } gate_st_t;

    // balance encoding: 2'b00 even, 2'b01 A ahead, 2'b11 B ahead
    localparam logic [1:0] BAL_EVEN   = 2'b00;
    localparam logic [1:0] BAL_A_LEAD = 2'b01;
    localparam logic [1:0] BAL_B_LEAD = 2'b11;

endpackage

// File: rtl/pskip_duty_meter.sv
module pskip_duty_meter #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pri_on,
    output logic low_duty
);
    localparam int          CMP_W   = CNT_W + 3;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] on_cnt;
        logic [CNT_W-1:0] per_cnt;
    } meter_st_t;

    meter_st_t st_q, st_d;

    logic [CMP_W-1:0] on_now;
    logic [CMP_W-1:0] per_now;

    // on-count and length of the period that ends at this edge
    always_comb begin
        on_now   = CMP_W'(st_q.on_cnt) + CMP_W'(pri_on);
        per_now  = CMP_W'(st_q.per_cnt) + CMP_W'(1);
        low_duty = (on_now << 2) < per_now;

        st_d = st_q;
        if (tick) begin
            st_d.on_cnt  = '0;
            st_d.per_cnt = '0;
        end else begin
            if (pri_on && st_q.on_cnt != CNT_MAX) begin
                st_d.on_cnt = st_q.on_cnt + CNT_W'(1);
            end
            if (st_q.per_cnt != CNT_MAX) begin
                st_d.per_cnt = st_q.per_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_on_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.on_cnt <= st_q.per_cnt + CNT_W'(1) || st_q.per_cnt == CNT_MAX)
        else $error("on-count exceeds period count");

endmodule

// File: rtl/pskip_balance.sv
module pskip_balance
    import pskip_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pp_mode,
    input  logic   commit,
    input  phase_e commit_phase,
    output logic   ok_a,
    output logic   ok_b
);
    logic [1:0] bal_q, bal_d;

    always_comb begin
        bal_d = bal_q;
        if (commit && pp_mode) begin
            if (commit_phase == PH_A) begin
                bal_d = (bal_q == BAL_B_LEAD) ? BAL_EVEN : BAL_A_LEAD;
            end else begin
                bal_d = (bal_q == BAL_A_LEAD) ? BAL_EVEN : BAL_B_LEAD;
            end
        end
        ok_a = !pp_mode || (bal_q != BAL_A_LEAD);
        ok_b = !pp_mode || (bal_q != BAL_B_LEAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bal_q <= BAL_EVEN;
        end else begin
            bal_q <= bal_d;
        end
    end

    // R7: a leading phase may never take another skip
    a_r7_no_lead_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && pp_mode) |->
            !((commit_phase == PH_A && bal_q == BAL_A_LEAD) ||
              (commit_phase == PH_B && bal_q == BAL_B_LEAD)))
        else $error("skip granted to leading phase");

    a_r7_balance_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bal_q != 2'b10)
        else $error("balance out of range");

    a_r1_reset_even: assert property (@(posedge clk)
        !rst_n |=> bal_q == BAL_EVEN)
        else $error("balance not cleared by reset");

endmodule

// File: rtl/pskip_gate.sv
module pskip_gate
    import pskip_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    input  logic pwm_in,
    input  logic cmp_low,
    input  logic ss_done,
    input  logic pp_mode,
    output logic pri_a,
    output logic pri_b,
    output logic sr_a,
    output logic sr_b
);
    gate_st_t st_q, st_d;

    logic low_duty;
    logic ok_a;
    logic ok_b;
    logic commit;
    logic phase_ok;
    logic pulse;

    pskip_duty_meter #(
        .CNT_W (CNT_W)
    ) i_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sys_tick),
        .pri_on   (st_q.pri_a | st_q.pri_b),
        .low_duty (low_duty)
    );

    pskip_balance i_balance (
        .clk          (clk),
        .rst_n        (rst_n),
        .pp_mode      (pp_mode),
        .commit       (commit),
        .commit_phase (st_d.phase),
        .ok_a         (ok_a),
        .ok_b         (ok_b)
    );

    always_comb begin
        st_d     = st_q;
        phase_ok = 1'b0;
        if (sys_tick) begin
            st_d.run   = 1'b1;
            st_d.phase = pp_mode ? ((st_q.phase == PH_A) ? PH_B : PH_A) : PH_A;
            phase_ok   = (st_d.phase == PH_A) ? ok_a : ok_b;
            st_d.skip  = st_q.run && cmp_low && low_duty && phase_ok;
        end
        commit = sys_tick && st_d.skip;

        pulse      = pwm_in && st_d.run && !st_d.skip;
        st_d.pri_a = pulse && (st_d.phase == PH_A);
        st_d.pri_b = pulse && (st_d.phase == PH_B) && pp_mode;

        if (pp_mode) begin
            st_d.sr_a = ss_done && st_d.run && !st_d.pri_b;
            st_d.sr_b = ss_done && st_d.run && !st_d.pri_a;
        end else begin
            st_d.sr_a = ss_done && st_d.run && !st_d.pri_a;
            st_d.sr_b = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_B, default: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pri_a = st_q.pri_a;
    assign pri_b = st_q.pri_b;
    assign sr_a  = st_q.sr_a;
    assign sr_b  = st_q.sr_b;

    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> !pri_a && !pri_b && !sr_a && !sr_b)
        else $error("outputs not cleared by reset");

    a_r2_no_skip_high_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_tick && !low_duty) |=> !st_q.skip)
        else $error("skip with duty at or above one quarter");

    a_r2_no_skip_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_tick && !cmp_low) |=> !st_q.skip)
        else $error("skip without low-voltage flag");

    a_r3_quiet_skip: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.skip |-> !pri_a && !pri_b)
        else $error("primary high in skipped period");

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_a && pri_b))
        else $error("both primaries high");

    a_r6_sr_off_in_softstart: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ss_done) |-> !sr_a && !sr_b)
        else $error("rectifier on before soft-start done");

    a_r8_single_ended_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pp_mode) |-> !pri_b && !sr_b)
        else $error("phase B active in single-ended mode");

    a_r9_first_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_tick && !st_q.run) |=> !st_q.skip)
        else $error("first period after reset skipped");

endmodule

// File: tb/test_pskip_gate.sv
module test_pskip_gate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_tick = 1'b0;
    logic pwm_in = 1'b0;
    logic cmp_low = 1'b0;
    logic ss_done = 1'b0;
    logic pp_mode = 1'b1;
    logic pri_a, pri_b, sr_a, sr_b;

    int n_checks = 0;
    int n_fail   = 0;

    // bench reference state
    bit m_started;
    bit m_phase_b;
    int m_prev_on;
    int m_prev_per;
    int m_skips_a;
    int m_skips_b;
    bit last_skip;

    always #5 clk = ~clk;

    pskip_gate i_pskip_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_tick (sys_tick),
        .pwm_in   (pwm_in),
        .cmp_low  (cmp_low),
        .ss_done  (ss_done),
        .pp_mode  (pp_mode),
        .pri_a    (pri_a),
        .pri_b    (pri_b),
        .sr_a     (sr_a),
        .sr_b     (sr_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reset_dut(input bit pp);
        @(negedge clk);
        rst_n    = 1'b0;
        sys_tick = 1'b0;
        pwm_in   = 1'b1;
        cmp_low  = 1'b1;
        pp_mode  = pp;
        repeat (3) @(negedge clk);
        chk({pri_a, pri_b, sr_a, sr_b} == 4'b0000, "R1 outputs in reset",
            int'({pri_a, pri_b, sr_a, sr_b}), 0);
        rst_n  = 1'b1;
        pwm_in = 1'b0;
        m_started  = 0;
        m_phase_b  = 1;
        m_prev_on  = 0;
        m_prev_per = 0;
        m_skips_a  = 0;
        m_skips_b  = 0;
    endtask

    // one switching period of P clocks with N high pwm clocks
    task automatic run_cycle(input int P, input int N, input bit flag, input string tag);
        bit skip;
        bit ok_phase;
        int cnt_a = 0;
        int cnt_b = 0;
        int sr_bad = 0;
        int diff;
        m_phase_b = pp_mode ? !m_phase_b : 1'b0;
        diff = m_skips_a - m_skips_b;
        ok_phase = !pp_mode || (m_phase_b ? (diff >= 0) : (diff <= 0));
        skip = m_started && flag && (4 * m_prev_on < m_prev_per) && ok_phase;
        for (int k = 0; k < P; k++) begin
            bit ea, eb, esa, esb;
            @(negedge clk);
            sys_tick = (k == 0);
            pwm_in   = (k < N);
            cmp_low  = flag;
            @(posedge clk);
            #2;
            ea  = !skip && !m_phase_b && (k < N);
            eb  = pp_mode && !skip && m_phase_b && (k < N);
            esa = ss_done && (pp_mode ? !eb : !ea);
            esb = pp_mode && ss_done && !ea;
            if (pri_a) cnt_a++;
            if (pri_b) cnt_b++;
            if (sr_a != esa || sr_b != esb) sr_bad++;
        end
        chk(cnt_a == ((!skip && !m_phase_b) ? N : 0), {tag, " pri_a count"}, cnt_a,
            (!skip && !m_phase_b) ? N : 0);
        chk(cnt_b == ((pp_mode && !skip && m_phase_b) ? N : 0), {tag, " pri_b count"}, cnt_b,
            (pp_mode && !skip && m_phase_b) ? N : 0);
        chk(sr_bad == 0, ss_done ? "R5 rectifier levels" : "R6 rectifier levels", sr_bad, 0);
        if (skip && pp_mode) begin
            if (m_phase_b) m_skips_b++; else m_skips_a++;
        end
        if (pp_mode) begin
            diff = m_skips_a - m_skips_b;
            chk(diff <= 1 && diff >= -1, "R7 skip count spread", diff, 0);
        end
        last_skip  = skip;
        m_prev_on  = skip ? 0 : N;
        m_prev_per = P;
        m_started  = 1;
    endtask

    task automatic t_normal_alternation;
        ss_done = 1'b0;
        reset_dut(1'b1);
        run_cycle(40, 20, 1'b1, "R9 first period");
        chk(!last_skip, "R9 first period not skipped", last_skip, 0);
        run_cycle(40, 20, 1'b0, "R4 phase B");
        run_cycle(40, 20, 1'b0, "R4 phase A");
    endtask

    task automatic t_boundary_duty;
        // exactly 25%: 4*10 == 40, must not skip
        run_cycle(40, 10, 1'b0, "R2 set quarter");
        run_cycle(40, 10, 1'b1, "R2 quarter duty flagged");
        chk(!last_skip, "R2 no skip at 25 percent", last_skip, 0);
        run_cycle(40, 9, 1'b1, "R2 quarter duty again");
        chk(!last_skip, "R2 no skip after 25 percent", last_skip, 0);
        // low duty but flag low
        run_cycle(40, 5, 1'b0, "R2 low duty no flag");
        chk(!last_skip, "R2 no skip without flag", last_skip, 0);
    endtask

    task automatic t_softstart_skip;
        // still in soft-start: skips happen with rectifiers off
        run_cycle(40, 5, 1'b1, "R3 skip in soft-start");
        chk(last_skip, "R3 skip taken", last_skip, 1);
        run_cycle(40, 5, 1'b1, "R6 skip in soft-start");
        chk(m_skips_a == m_skips_b, "R7 pair equal", m_skips_a - m_skips_b, 0);
    endtask

    task automatic t_after_softstart;
        ss_done = 1'b1;
        for (int p = 0; p < 3; p++) begin
            run_cycle(40, 5, 1'b1, "R5 skip A/B");
            run_cycle(40, 5, 1'b1, "R5 skip B/A");
            chk(m_skips_a == m_skips_b, "R7 equal after pair", m_skips_a - m_skips_b, 0);
        end
    endtask

    task automatic t_lead_refused;
        bit ph;
        ss_done = 1'b1;
        reset_dut(1'b1);
        run_cycle(40, 5, 1'b0, "R4 start");      // A, normal
        run_cycle(40, 5, 1'b1, "R3 lone skip");  // B, skipped
        chk(last_skip, "R7 lone skip taken", last_skip, 1);
        run_cycle(40, 8, 1'b0, "R4 A normal");   // A, normal
        run_cycle(40, 8, 1'b1, "R7 leader flagged"); // B leads: refused
        ph = m_phase_b;
        chk(ph && !last_skip, "R7 leading phase refused", last_skip, 0);
        run_cycle(40, 8, 1'b1, "R7 trailing phase"); // A may skip
        chk(last_skip, "R7 trailing phase skips", last_skip, 1);
        chk(m_skips_a == m_skips_b, "R7 rebalanced", m_skips_a - m_skips_b, 0);
    endtask

    task automatic t_single_ended;
        ss_done = 1'b1;
        reset_dut(1'b0);
        run_cycle(40, 6, 1'b0, "R8 single A");
        run_cycle(40, 6, 1'b1, "R8 single skip 1");
        chk(last_skip, "R8 skip taken", last_skip, 1);
        run_cycle(40, 6, 1'b1, "R8 single skip 2");
        chk(last_skip, "R8 repeated skip on A", last_skip, 1);
        run_cycle(40, 20, 1'b0, "R8 single normal");
    endtask

    initial begin
        t_normal_alternation;
        t_boundary_duty;
        t_softstart_skip;
        t_after_softstart;
        t_lead_refused;
        t_single_ended;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule